// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a host register bus and a downstream configuration-access port. Software sees two windows, each 4 KB and little-endian. The first window holds a 32-bit configuration address word. The second window is a data port. Each read or write of the data port takes the stored word, merges it with the low offset bits of the access, and turns the result into a conventional bus/device/function/register configuration address. It then issues exactly one configuration transaction downstream, carrying the write data, the byte length and the direction, and holds the host access until the downstream side answers.

The stored word can be written in any of three encodings. If bit 31 is set, the word passes straight through. If bit 31 is clear and bit 0 is set, the word is a type-1 style word. If both are clear, the word is a type-0 style word whose device is selected by a one-hot IDSEL bit somewhere in bits [31:11].

The control is a four-state machine:
- ST_IDLE waits for a host access. From there it moves to ST_RESP for address-window accesses and for type-0 words with no IDSEL bit set. It moves to ST_REQ for every other data-port access.
- ST_REQ drives a one-cycle downstream request. It moves to ST_RESP if the response arrives in that same cycle, and to ST_WAIT otherwise.
- ST_WAIT holds until the response arrives, then moves to ST_RESP.
- ST_RESP raises the host ready for one cycle and returns to ST_IDLE.

Top module: `cfg_access_xlate`

## Requirements
- R1: When stored bit 31 is 1, the outgoing address is the stored word ORed with host_off[1:0] in bits [1:0].
- R2: When stored bit 31 is 0 and bit 0 is 1, the outgoing address is the stored bits [31:3] followed by host_off[2:0] in bits [2:0].
- R3: When stored bits 31 and 0 are both 0, the slot is the index of the lowest set bit in stored bits [31:11], counted from bit 11 as slot 0. Higher set bits are ignored. The slot goes in outgoing bits [15:11].
- R4: In type-0 style, outgoing bits [10:8] equal stored bits [10:8], bits [7:3] equal stored bits [7:3], and bits [2:0] equal host_off[2:0]. Bits [31:16] are zero.
- R5: A type-0 word with stored bits [31:11] all zero issues no downstream request. A read then returns 32'hFFFF_FFFF and a write is discarded, and the host still completes.
- R6: A write to the address window (host_win=0) updates only the bytes whose host_be bit is set, where bit n covers data bits [8n+7:8n]. A read of the address window returns the stored word.
- R7: A data-port access (host_win=1) passes host_we, host_len (1, 2 or 4) and host_wdata unchanged to the downstream request. A read returns the downstream response data.
- R8: Each translated data-port access issues exactly one single-cycle downstream request. host_ready is not raised before the downstream response.
- R9: Reset clears the stored word to zero and abandons any outstanding downstream request. No request and no host ready follow the reset.
- R10: When bits 31 and 0 are both set, the pass-through rule (R1) takes precedence over type-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request, held until host_ready |
| host_win | input | 1 | Window select: 0 address word, 1 data port |
| host_we | input | 1 | 1 write, 0 read |
| host_off | input | 3 | Low byte-offset bits of the access within the window |
| host_be | input | 4 | Byte enables for address-window writes |
| host_len | input | 3 | Data-port access length in bytes (1, 2, 4) |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Access complete; host_rdata valid |
| host_rdata | output | 32 | Host read data |
| cfg_req_valid | output | 1 | Downstream configuration request, one cycle |
| cfg_req_addr | output | 32 | Translated configuration address |
| cfg_req_we | output | 1 | Downstream direction |
| cfg_req_len | output | 3 | Downstream byte length |
| cfg_req_wdata | output | 32 | Downstream write data |
| cfg_rsp_valid | input | 1 | Downstream completion |
| cfg_rsp_rdata | input | 32 | Downstream read data |

## Verification
The hardest situation to reach from the ports is a reset arriving while a downstream request is outstanding. The bench starts a translated data-port access and lets the request go out. It then withholds the response and pulls reset before any completion. Afterwards it watches for a late request or a stray ready, and reads back the cleared address word. A second hard case is the zero-latency response that lands in the same cycle as the request. The bench alternates response latencies between zero and several cycles, so the path from ST_REQ straight to ST_RESP is taken as well as the path through ST_WAIT.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_RESP
    } cfgx_state_e;

    typedef enum logic [1:0] {
        FMT_PASS,
        FMT_TYPE1,
        FMT_TYPE0
    } cfgx_fmt_e;
endpackage

// File: rtl/cfgx_addr_reg.sv
module cfgx_addr_reg #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW/8-1:0] be,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   word
);
    localparam int NB = DW / 8;

    logic [DW-1:0] word_q;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[b*8 +: 8] <= '0;
            end else if (wr_en && be[b]) begin
                word_q[b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    assign word = word_q;

    // R6: stored word only changes on an address-window write
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(word_q));
endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
    import cfgx_pkg::*;
#(
    parameter int DW       = 32,
    parameter int IDSEL_LO = 11,
    parameter int SLOT_W   = 5,
    parameter int FN_W     = 3,
    parameter int OFF_W    = 3
) (
    input  logic [DW-1:0]    stored,
    input  logic [OFF_W-1:0] off,
    output logic [DW-1:0]    xaddr,
    output logic             idsel_miss
);
    localparam int FN_LO = IDSEL_LO - FN_W;

    cfgx_fmt_e         fmt;
    logic [SLOT_W-1:0] slot;
    logic              found;

    always_comb begin
        if (stored[DW-1])   fmt = FMT_PASS;
        else if (stored[0]) fmt = FMT_TYPE1;
        else                fmt = FMT_TYPE0;
    end

    // Lowest set IDSEL bit wins: scan downward so the last hit is the lowest.
    always_comb begin
        slot  = '0;
        found = 1'b0;
        for (int i = DW - 1; i >= IDSEL_LO; i--) begin
            if (stored[i]) begin
                slot  = SLOT_W'(i - IDSEL_LO);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        xaddr = '0;
        unique case (fmt)
            FMT_PASS: begin
                xaddr = stored;
                xaddr[1:0] = stored[1:0] | off[1:0];
            end
            FMT_TYPE1: begin
                xaddr = {stored[DW-1:OFF_W], off};
            end
            default: begin
                xaddr[IDSEL_LO +: SLOT_W]  = slot;
                xaddr[FN_LO +: FN_W]       = stored[FN_LO +: FN_W];
                xaddr[FN_LO-1:OFF_W]       = stored[FN_LO-1:OFF_W];
                xaddr[OFF_W-1:0]           = off;
            end
        endcase
    end

    assign idsel_miss = (fmt == FMT_TYPE0) && !found;

    always_comb begin
        // R4: type-0 result never carries bits above the slot field
        if (fmt == FMT_TYPE0)
            p_type0_upper_zero_r4: assert (xaddr[DW-1:IDSEL_LO+SLOT_W] == '0);
        // R1: pass-through keeps every stored bit above the offset lanes
        if (fmt == FMT_PASS)
            p_pass_keeps_r1: assert (xaddr[DW-1:2] == stored[DW-1:2]);
    end
endmodule

// File: rtl/cfgx_fsm.sv
module cfgx_fsm
    import cfgx_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_valid,
    input  logic             host_win,
    input  logic             host_we,
    input  logic [LEN_W-1:0] host_len,
    input  logic [DW-1:0]    host_wdata,
    input  logic [DW-1:0]    xaddr,
    input  logic             idsel_miss,
    input  logic [DW-1:0]    stored,
    input  logic             cfg_rsp_valid,
    input  logic [DW-1:0]    cfg_rsp_rdata,
    output logic             addr_wr_en,
    output logic             host_ready,
    output logic [DW-1:0]    host_rdata,
    output logic             cfg_req_valid,
    output logic [DW-1:0]    cfg_req_addr,
    output logic             cfg_req_we,
    output logic [LEN_W-1:0] cfg_req_len,
    output logic [DW-1:0]    cfg_req_wdata
);
    cfgx_state_e state_q, state_d;
    logic        accept;
    logic [DW-1:0]    rdata_q, addr_q, wdata_q;
    logic             we_q;
    logic [LEN_W-1:0] len_q;

    assign accept = (state_q == ST_IDLE) && host_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_valid) begin
                    if (host_win && !idsel_miss) state_d = ST_REQ;
                    else                         state_d = ST_RESP;
                end
            end
            ST_REQ:  state_d = cfg_rsp_valid ? ST_RESP : ST_WAIT;
            ST_WAIT: if (cfg_rsp_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            len_q   <= '0;
        end else if (accept) begin
            if (!host_win) begin
                rdata_q <= stored;
            end else if (idsel_miss) begin
                rdata_q <= '1;
            end else begin
                addr_q  <= xaddr;
                wdata_q <= host_wdata;
                we_q    <= host_we;
                len_q   <= host_len;
            end
        end else if ((state_q == ST_REQ || state_q == ST_WAIT) && cfg_rsp_valid) begin
            rdata_q <= cfg_rsp_rdata;
        end
    end

    always_comb begin
        addr_wr_en    = accept && !host_win && host_we;
        cfg_req_valid = (state_q == ST_REQ);
        host_ready    = (state_q == ST_RESP);
        host_rdata    = rdata_q;
        cfg_req_addr  = addr_q;
        cfg_req_we    = we_q;
        cfg_req_len   = len_q;
        cfg_req_wdata = wdata_q;
    end

    // R8: a request lasts one cycle only
    p_req_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |=> !cfg_req_valid);
    // R8: host is never released in the cycle a request is outstanding
    p_no_ready_with_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> !host_ready);
    // R5: an empty IDSEL field completes with no downstream request
    p_miss_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && host_win && idsel_miss) |=> (!cfg_req_valid && host_ready));
endmodule

// File: rtl/cfg_access_xlate.sv
module cfg_access_xlate
    import cfgx_pkg::*;
#(
    parameter int DW       = 32,
    parameter int LEN_W    = 3,
    parameter int OFF_W    = 3,
    parameter int IDSEL_LO = 11,
    parameter int SLOT_W   = 5,
    parameter int FN_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_valid,
    input  logic                host_win,
    input  logic                host_we,
    input  logic [OFF_W-1:0]    host_off,
    input  logic [DW/8-1:0]     host_be,
    input  logic [LEN_W-1:0]    host_len,
    input  logic [DW-1:0]       host_wdata,
    output logic                host_ready,
    output logic [DW-1:0]       host_rdata,
    output logic                cfg_req_valid,
    output logic [DW-1:0]       cfg_req_addr,
    output logic                cfg_req_we,
    output logic [LEN_W-1:0]    cfg_req_len,
    output logic [DW-1:0]       cfg_req_wdata,
    input  logic                cfg_rsp_valid,
    input  logic [DW-1:0]       cfg_rsp_rdata
);
    logic [DW-1:0] stored;
    logic [DW-1:0] xaddr;
    logic          idsel_miss;
    logic          addr_wr_en;

    cfgx_addr_reg #(.DW(DW)) u_areg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (addr_wr_en),
        .be    (host_be),
        .wdata (host_wdata),
        .word  (stored)
    );

    cfgx_xlate #(
        .DW(DW), .IDSEL_LO(IDSEL_LO), .SLOT_W(SLOT_W), .FN_W(FN_W), .OFF_W(OFF_W)
    ) u_xlate (
        .stored     (stored),
        .off        (host_off),
        .xaddr      (xaddr),
        .idsel_miss (idsel_miss)
    );

    cfgx_fsm #(.DW(DW), .LEN_W(LEN_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_valid    (host_valid),
        .host_win      (host_win),
        .host_we       (host_we),
        .host_len      (host_len),
        .host_wdata    (host_wdata),
        .xaddr         (xaddr),
        .idsel_miss    (idsel_miss),
        .stored        (stored),
        .cfg_rsp_valid (cfg_rsp_valid),
        .cfg_rsp_rdata (cfg_rsp_rdata),
        .addr_wr_en    (addr_wr_en),
        .host_ready    (host_ready),
        .host_rdata    (host_rdata),
        .cfg_req_valid (cfg_req_valid),
        .cfg_req_addr  (cfg_req_addr),
        .cfg_req_we    (cfg_req_we),
        .cfg_req_len   (cfg_req_len),
        .cfg_req_wdata (cfg_req_wdata)
    );
endmodule

// File: tb/cfg_access_xlate_tb.sv
`timescale 1ns/1ps
module cfg_access_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0, host_win = 1'b0, host_we = 1'b0;
    logic [2:0]  host_off = '0;
    logic [3:0]  host_be = '0;
    logic [2:0]  host_len = 3'd4;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        cfg_req_valid, cfg_req_we;
    logic [31:0] cfg_req_addr, cfg_req_wdata;
    logic [2:0]  cfg_req_len;
    logic        cfg_rsp_valid = 1'b0;
    logic [31:0] cfg_rsp_rdata = '0;

    int tests = 0, fails = 0;
    int req_cnt, lat_sel = 0;
    logic [31:0] cap_addr, cap_wdata;
    logic        cap_we, early_ready;
    logic [2:0]  cap_len;

    always #2 clk = ~clk;

    cfg_access_xlate u_dut (.*);

    function automatic logic [31:0] rsp_of(logic [31:0] a, logic [2:0] l);
        return a ^ 32'hC0DE_0000 ^ {29'b0, l};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic win, input logic we, input logic [2:0] off,
                          input logic [3:0] be, input logic [2:0] len,
                          input logic [31:0] wd, output logic [31:0] rd);
        int cyc, lat_left;
        bit rsp_given;
        req_cnt = 0; early_ready = 1'b0; rsp_given = 0; lat_left = -1; rd = 'x;
        @(negedge clk);
        host_valid = 1; host_win = win; host_we = we; host_off = off;
        host_be = be; host_len = len; host_wdata = wd;
        cyc = 0;
        while (cyc < 100) begin
            @(negedge clk);
            cyc++;
            cfg_rsp_valid = 1'b0;
            if (host_ready) begin
                rd = host_rdata;
                early_ready = (req_cnt > 0) && !rsp_given;
                break;
            end
            if (cfg_req_valid) begin
                req_cnt++;
                cap_addr = cfg_req_addr; cap_we = cfg_req_we;
                cap_len = cfg_req_len; cap_wdata = cfg_req_wdata;
                lat_left = lat_sel;
                lat_sel = (lat_sel + 1) % 4;
            end
            if (lat_left == 0) begin
                cfg_rsp_valid = 1'b1;
                cfg_rsp_rdata = rsp_of(cap_addr, cap_len);
                rsp_given = 1;
                lat_left = -1;
            end else if (lat_left > 0) begin
                lat_left--;
            end
        end
        if (cyc >= 100) chk("R8 host hang", 32'd0, 32'd1);
        host_valid = 0;
    endtask

    task automatic set_word(input logic [31:0] w);
        logic [31:0] d;
        access(1'b0, 1'b1, 3'd0, 4'hF, 3'd4, w, d);
    endtask

    // Full translated-access check: address, forwarding and single request.
    task automatic data_rt(input string req, input logic [31:0] w, input logic [2:0] off,
                           input logic [31:0] exp, input logic we, input logic [2:0] len);
        logic [31:0] d, wd;
        wd = w ^ {off, 29'h0ABC_DEF};
        set_word(w);
        access(1'b1, we, off, 4'h0, len, wd, d);
        chk({req, " R8 req count"}, req_cnt, 1);
        chk({req, " R8 early ready"}, {31'b0, early_ready}, 0);
        chk({req, " addr"}, cap_addr, exp);
        chk("R7 we", {31'b0, cap_we}, {31'b0, we});
        chk("R7 len", {29'b0, cap_len}, {29'b0, len});
        if (we) chk("R7 wdata", cap_wdata, wd);
        else    chk("R7 rdata", d, rsp_of(exp, len));
    endtask

    function automatic logic [2:0] len_pick(int k);
        return (k % 3 == 0) ? 3'd1 : (k % 3 == 1) ? 3'd2 : 3'd4;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=hang exp=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, w, e, mrg;
        int k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state of the stored word
        access(1'b0, 1'b0, 3'd0, 4'h0, 3'd4, 32'h0, d);
        chk("R9 reset word", d, 32'h0);

        // R6: byte-enable sweep on the address window
        for (int be = 0; be < 16; be++) begin
            set_word(32'hFFFF_FFFF);
            access(1'b0, 1'b1, 3'd0, 4'(be), 3'd4, 32'h1234_5678, d);
            for (int b = 0; b < 4; b++)
                mrg[b*8 +: 8] = be[b] ? 8'(32'h1234_5678 >> (8*b)) : 8'hFF;
            access(1'b0, 1'b0, 3'd0, 4'h0, 3'd4, 32'h0, d);
            chk("R6 be merge", d, mrg);
        end

        // R1 pass-through and R10 precedence over type-1
        for (int i = 0; i < 6; i++) begin
            w = 32'h8000_0000 | (32'h0135_7BD8 * (i + 1));
            if (i % 2 == 1) w[0] = 1'b1;
            for (int off = 0; off < 8; off++) begin
                e = w | {30'b0, 2'(off)};
                data_rt((i % 2 == 1) ? "R10" : "R1", w, 3'(off), e, off[0], len_pick(k++));
            end
        end

        // R2 type-1 style
        for (int i = 0; i < 6; i++) begin
            w = ((32'h1D2C_3B47 * (i + 3)) & 32'h7FFF_FFFF) | 32'h1;
            for (int off = 0; off < 8; off++) begin
                e = {w[31:3], 3'(off)};
                data_rt("R2", w, 3'(off), e, off[1], len_pick(k++));
            end
        end

        // R3/R4 type-0: every reachable slot, every function, extra higher IDSEL bits
        for (int s = 0; s < 20; s++) begin
            for (int f = 0; f < 8; f++) begin
                for (int o = 0; o < 3; o++) begin
                    logic [2:0] off;
                    logic [4:0] rg;
                    off = (o == 0) ? 3'd0 : (o == 1) ? 3'd5 : 3'd7;
                    rg  = 5'(s * 7 + f * 3 + o);
                    w = (32'h1 << (11 + s)) | ((32'h7FFF_F800 << (s + 1 + (f % 2))) & 32'h7FFF_F800)
                        | (32'(f) << 8) | (32'(rg) << 3) | {29'b0, off & 3'b110};
                    e = (32'(s) << 11) | (32'(f) << 8) | (32'(rg) << 3) | {29'b0, off};
                    data_rt("R3 R4", w, off, e, (f + o) % 2 == 1, len_pick(k++));
                end
            end
        end

        // R5: empty IDSEL field, read and write
        for (int i = 0; i < 4; i++) begin
            w = (32'(i) << 8) | (32'(i * 9) << 3);
            set_word(w);
            access(1'b1, 1'b0, 3'(i), 4'h0, 3'd4, 32'h0, d);
            chk("R5 miss read data", d, 32'hFFFF_FFFF);
            chk("R5 miss read no req", req_cnt, 0);
            access(1'b1, 1'b1, 3'(i), 4'h0, 3'd2, 32'hDEAD_BEEF, d);
            chk("R5 miss write no req", req_cnt, 0);
            access(1'b0, 1'b0, 3'd0, 4'h0, 3'd4, 32'h0, d);
            chk("R5 word untouched", d, w);
        end

        // R9: reset while a downstream request is outstanding
        begin
            int reqs = 0, rdys = 0;
            set_word(32'h0000_0A01);
            @(negedge clk);
            host_valid = 1; host_win = 1; host_we = 0; host_off = 3'd2; host_len = 3'd4;
            @(negedge clk);
            chk("R9 request out", {31'b0, cfg_req_valid}, 32'd1);
            host_valid = 0;
            rst_n = 0;
            @(negedge clk);
            @(negedge clk);
            rst_n = 1;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (cfg_req_valid) reqs++;
                if (host_ready) rdys++;
            end
            chk("R9 no request after reset", reqs, 0);
            chk("R9 no ready after reset", rdys, 0);
            access(1'b0, 1'b0, 3'd0, 4'h0, 3'd4, 32'h0, d);
            chk("R9 word cleared", d, 32'h0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule